// File: doc/BRIEF.md
# Rank-Aware Request Selector

This block picks the next DRAM request to issue from a small queue of pending entries. Each entry carries a valid bit, a rank, a bank within that rank and a row. The selector also receives one availability bit per rank (low while that rank is being refreshed), the open-row state of every bank, the rank served by the previous burst, a flag that says the command direction has just changed, and a mask of the banks that can be prepared earliest. It returns the index of the chosen entry, the flat bank id and bank group of that entry, and a flag that says whether any entry was chosen.

Two policies are offered. The first serves the oldest entry whose rank is available. The second puts row hits first. Among hits it prefers the rank of the previous burst, and drops that preference when the command type has just switched. If no entry hits its open row, the oldest entry to one of the earliest-ready banks is taken. Because entries to refreshing ranks are skipped, one rank can keep the data bus busy while another rank refreshes. Selection is computed combinationally over the queue and is registered once before it reaches the outputs.

Top module: `rank_aware_selector`

## Requirements
- R1: An entry whose rank has `rank_avail_i` low is never selected. When no entry is eligible under the active policy, `found_o` is 0.
- R2: When exactly one entry is valid, `found_o` is 1 exactly when that entry's rank is available, and that entry is selected in either policy, regardless of row hits and the earliest mask.
- R3: With `mode_frfcfs_i`=0, the lowest-index valid entry with an available rank is selected. Index 0 is the oldest.
- R4: With `mode_frfcfs_i`=1, a row hit counts as preferred when its rank equals `last_rank_i`, or when `cmd_switched_i`=1. A row hit means `row_open_i` is set at the entry's bank id and the entry's row equals `open_row_i` at that bank id. The lowest-index preferred hit is selected.
- R5: With `mode_frfcfs_i`=1 and no preferred hit, the lowest-index row hit to any other available rank is selected, ahead of every non-hit entry.
- R6: With `mode_frfcfs_i`=1 and no available row hit, the lowest-index available entry whose bit is set in `earliest_mask_i` (indexed by bank id) is selected. If there is none, `found_o` is 0.
- R7: The bank id is rank × BANKS + bank and appears on `sel_bank_id_o`. The bank group on `sel_group_o` is bank mod BANK_GROUPS, or the bank number itself when BANK_GROUPS is 0.
- R8: The outputs reflect the inputs sampled at the previous rising edge of `clk_i`. While `rst_ni` is low, all outputs are 0.
- R9: Entries with `valid_i` low are never selected and never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_frfcfs_i | input | 1 | 0: oldest-first, 1: row-hit-first |
| cmd_switched_i | input | 1 | Command direction just changed |
| last_rank_i | input | RANK_W | Rank of the previous burst |
| rank_avail_i | input | RANKS | Per-rank availability (low while refreshing) |
| valid_i | input | DEPTH | Entry valid bits |
| rank_i | input | DEPTH*RANK_W | Entry ranks, entry i at bits [i*RANK_W +: RANK_W] |
| bank_i | input | DEPTH*BANK_W | Entry banks within the rank |
| row_i | input | DEPTH*ROW_W | Entry rows |
| row_open_i | input | RANKS*BANKS | Per-bank open-row flag, by bank id |
| open_row_i | input | RANKS*BANKS*ROW_W | Per-bank open row, by bank id |
| earliest_mask_i | input | RANKS*BANKS | Earliest-ready banks, by bank id |
| found_o | output | 1 | An entry was selected |
| sel_idx_o | output | IDX_W | Selected entry index |
| sel_bank_id_o | output | ID_W | Flat bank id of the selected entry |
| sel_group_o | output | BANK_W | Bank group of the selected entry |

## Verification
The assertions check on every cycle that a selected entry always has an available rank, that no selection is reported when nothing is eligible, that the oldest-first policy never skips an older eligible entry, that a hit always wins over a miss when several entries are queued, and that the registered outputs follow the previous cycle's choice. The ordering within the row-hit policy can only be shown by the bench's scenarios. This covers preferring the last rank, lifting that preference on a direction switch, the fallback to another rank's hit, and the fallback to the earliest-bank mask. The same holds for the single-entry rule and the bank id and group values.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  typedef enum logic {
    SEL_OLDEST  = 1'b0,
    SEL_HIT_1ST = 1'b1
  } sel_mode_e;

  function automatic int unsigned w_of(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsel_bank_map.sv
module rsel_bank_map #(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned BANKS       = 4,
  parameter int unsigned BANK_GROUPS = 2,
  parameter int unsigned RANK_W      = 1,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned ID_W        = 3
) (
  input  logic [DEPTH*RANK_W-1:0] rank_i,
  input  logic [DEPTH*BANK_W-1:0] bank_i,
  output logic [DEPTH*ID_W-1:0]   id_o,
  output logic [DEPTH*BANK_W-1:0] grp_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [RANK_W-1:0] r;
    logic [BANK_W-1:0] b;
    assign r = rank_i[e*RANK_W +: RANK_W];
    assign b = bank_i[e*BANK_W +: BANK_W];
    assign id_o[e*ID_W +: ID_W] = ID_W'(r) * ID_W'(BANKS) + ID_W'(b);
    if (BANK_GROUPS > 0) begin : g_grp
      assign grp_o[e*BANK_W +: BANK_W] = BANK_W'(32'(b) % BANK_GROUPS);
    end else begin : g_nogrp
      assign grp_o[e*BANK_W +: BANK_W] = b;
    end
  end
endmodule

// File: rtl/rsel_eligibility.sv
module rsel_eligibility #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned RANKS  = 2,
  parameter int unsigned NB     = 8,
  parameter int unsigned RANK_W = 1,
  parameter int unsigned ID_W   = 3,
  parameter int unsigned ROW_W  = 8
) (
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [DEPTH*RANK_W-1:0] rank_i,
  input  logic [DEPTH*ID_W-1:0]   id_i,
  input  logic [DEPTH*ROW_W-1:0]  row_i,
  input  logic [RANKS-1:0]        rank_avail_i,
  input  logic [NB-1:0]           row_open_i,
  input  logic [NB*ROW_W-1:0]     open_row_i,
  input  logic [NB-1:0]           earliest_mask_i,
  input  logic [RANK_W-1:0]       last_rank_i,
  input  logic                    cmd_switched_i,
  output logic [DEPTH-1:0]        avail_o,
  output logic [DEPTH-1:0]        hit_pref_o,
  output logic [DEPTH-1:0]        hit_any_o,
  output logic [DEPTH-1:0]        early_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [RANK_W-1:0] r;
    logic [ID_W-1:0]   id;
    logic              in_rng, hit;
    assign r      = rank_i[e*RANK_W +: RANK_W];
    assign id     = id_i[e*ID_W +: ID_W];
    assign in_rng = (32'(id) < NB) && (32'(r) < RANKS);
    assign avail_o[e] = valid_i[e] && in_rng && rank_avail_i[r];
    assign hit = in_rng && row_open_i[id] &&
                 (open_row_i[id*ROW_W +: ROW_W] == row_i[e*ROW_W +: ROW_W]);
    assign hit_any_o[e]  = avail_o[e] && hit;
    // same-rank preference lifted right after a direction switch
    assign hit_pref_o[e] = hit_any_o[e] && (cmd_switched_i || (r == last_rank_i));
    assign early_o[e]    = avail_o[e] && in_rng && earliest_mask_i[id];
  end
endmodule

// File: rtl/rsel_first_pick.sv
module rsel_first_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/rank_aware_selector.sv
module rank_aware_selector
  import rsel_pkg::*;
#(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned RANKS       = 2,
  parameter int unsigned BANKS       = 4,
  parameter int unsigned BANK_GROUPS = 2,
  parameter int unsigned ROW_W       = 8,
  localparam int unsigned RANK_W     = w_of(RANKS),
  localparam int unsigned BANK_W     = w_of(BANKS),
  localparam int unsigned NB         = RANKS * BANKS,
  localparam int unsigned ID_W       = w_of(NB),
  localparam int unsigned IDX_W      = w_of(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_frfcfs_i,
  input  logic                    cmd_switched_i,
  input  logic [RANK_W-1:0]       last_rank_i,
  input  logic [RANKS-1:0]        rank_avail_i,
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [DEPTH*RANK_W-1:0] rank_i,
  input  logic [DEPTH*BANK_W-1:0] bank_i,
  input  logic [DEPTH*ROW_W-1:0]  row_i,
  input  logic [NB-1:0]           row_open_i,
  input  logic [NB*ROW_W-1:0]     open_row_i,
  input  logic [NB-1:0]           earliest_mask_i,
  output logic                    found_o,
  output logic [IDX_W-1:0]        sel_idx_o,
  output logic [ID_W-1:0]         sel_bank_id_o,
  output logic [BANK_W-1:0]       sel_group_o
);
  logic [DEPTH*ID_W-1:0]   id_v;
  logic [DEPTH*BANK_W-1:0] grp_v;
  logic [DEPTH-1:0]        avail_v, hit_pref_v, hit_any_v, early_v, req_v;
  logic                    single_c, found_c;
  logic [IDX_W-1:0]        sel_c;
  sel_mode_e               mode;

  assign mode = sel_mode_e'(mode_frfcfs_i);

  rsel_bank_map #(
    .DEPTH(DEPTH), .BANKS(BANKS), .BANK_GROUPS(BANK_GROUPS),
    .RANK_W(RANK_W), .BANK_W(BANK_W), .ID_W(ID_W)
  ) u_map (
    .rank_i(rank_i), .bank_i(bank_i), .id_o(id_v), .grp_o(grp_v)
  );

  rsel_eligibility #(
    .DEPTH(DEPTH), .RANKS(RANKS), .NB(NB),
    .RANK_W(RANK_W), .ID_W(ID_W), .ROW_W(ROW_W)
  ) u_elig (
    .valid_i(valid_i), .rank_i(rank_i), .id_i(id_v), .row_i(row_i),
    .rank_avail_i(rank_avail_i), .row_open_i(row_open_i),
    .open_row_i(open_row_i), .earliest_mask_i(earliest_mask_i),
    .last_rank_i(last_rank_i), .cmd_switched_i(cmd_switched_i),
    .avail_o(avail_v), .hit_pref_o(hit_pref_v),
    .hit_any_o(hit_any_v), .early_o(early_v)
  );

  assign single_c = ($countones(valid_i) == 1);

  // priority tier: preferred hit > other-rank hit > earliest bank
  always_comb begin
    if (mode == SEL_OLDEST || single_c) req_v = avail_v;
    else if (|hit_pref_v)               req_v = hit_pref_v;
    else if (|hit_any_v)                req_v = hit_any_v;
    else                                req_v = early_v;
  end

  rsel_first_pick #(.N(DEPTH), .IW(IDX_W)) u_pick (
    .req_i(req_v), .found_o(found_c), .idx_o(sel_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_o       <= 1'b0;
      sel_idx_o     <= '0;
      sel_bank_id_o <= '0;
      sel_group_o   <= '0;
    end else begin
      found_o       <= found_c;
      sel_idx_o     <= found_c ? sel_c : '0;
      sel_bank_id_o <= found_c ? id_v[sel_c*ID_W +: ID_W] : '0;
      sel_group_o   <= found_c ? grp_v[sel_c*BANK_W +: BANK_W] : '0;
    end
  end

  AST_PICK_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_c |-> avail_v[sel_c]); // R1
  AST_NONE_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_v == '0) |-> !found_c); // R1
  AST_OLDEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SEL_OLDEST && found_c) |->
      ((avail_v & ((DEPTH'(1) << sel_c) - DEPTH'(1))) == '0)); // R3
  AST_HIT_OVER_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SEL_HIT_1ST && !single_c && |hit_any_v) |-> hit_any_v[sel_c]); // R5
  AST_VALID_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_c |-> valid_i[sel_c]); // R9
  AST_REG_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (found_o == $past(found_c))); // R8
endmodule

// File: tb/rank_aware_selector_test.sv
`timescale 1ns/1ps
module rank_aware_selector_test;
  localparam int D = 8, NR = 2, NBK = 4, NG = 2, RW = 8, NB = NR * NBK;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode = 1'b0, sw = 1'b0;
  logic [0:0] last_rank = '0;
  logic [NR-1:0] ravail = '0;
  logic [D-1:0] valid = '0;
  logic [D-1:0] rank_f = '0;
  logic [D*2-1:0] bank_f = '0;
  logic [D*RW-1:0] row_f = '0;
  logic [NB-1:0] ropen = '0, emask = '0;
  logic [NB*RW-1:0] orow_f = '0;
  logic found;
  logic [2:0] sidx, sid;
  logic [1:0] sgrp;

  int q_rank[D], q_bank[D], q_row[D], o_row[NB];
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rank_aware_selector uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_frfcfs_i(mode), .cmd_switched_i(sw),
    .last_rank_i(last_rank), .rank_avail_i(ravail), .valid_i(valid),
    .rank_i(rank_f), .bank_i(bank_f), .row_i(row_f), .row_open_i(ropen),
    .open_row_i(orow_f), .earliest_mask_i(emask), .found_o(found),
    .sel_idx_o(sidx), .sel_bank_id_o(sid), .sel_group_o(sgrp)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_q();
    valid = '0; ropen = '0; emask = '0; sw = 0; last_rank = '0;
    for (int i = 0; i < D; i++) begin q_rank[i] = 0; q_bank[i] = 0; q_row[i] = 0; end
    for (int b = 0; b < NB; b++) o_row[b] = 0;
  endtask

  // pack arrays and wait across one rising edge
  task automatic apply();
    for (int i = 0; i < D; i++) begin
      rank_f[i] = q_rank[i][0];
      bank_f[i*2 +: 2] = q_bank[i][1:0];
      row_f[i*RW +: RW] = q_row[i][RW-1:0];
    end
    for (int b = 0; b < NB; b++) orow_f[b*RW +: RW] = o_row[b][RW-1:0];
    @(negedge clk);
  endtask

  task automatic ref_pick(output bit f, output int idx);
    bit av[D], hp[D], ha[D], ea[D];
    int nv = 0;
    f = 0; idx = 0;
    for (int i = 0; i < D; i++) begin
      int id;
      id = q_rank[i] * NBK + q_bank[i];
      if (valid[i]) nv++;
      av[i] = valid[i] && ravail[q_rank[i]];
      ha[i] = av[i] && ropen[id] && (o_row[id] == q_row[i]);
      hp[i] = ha[i] && (sw || q_rank[i] == int'(last_rank));
      ea[i] = av[i] && emask[id];
    end
    if (!mode || nv == 1) begin
      for (int i = D - 1; i >= 0; i--) if (av[i]) begin f = 1; idx = i; end
    end else begin
      for (int i = D - 1; i >= 0; i--) if (ea[i]) begin f = 1; idx = i; end
      for (int i = D - 1; i >= 0; i--) if (ha[i]) begin f = 1; idx = i; end
      for (int i = D - 1; i >= 0; i--) if (hp[i]) begin f = 1; idx = i; end
    end
  endtask

  task automatic t_reset();
    chk("R8 reset found", found, 0);
    chk("R8 reset idx", sidx, 0);
    chk("R8 reset id", sid, 0);
  endtask

  task automatic t_fcfs();
    clear_q(); mode = 0; ravail = 2'b01;
    valid = 8'b0000_1111;
    q_rank[0] = 1; q_rank[1] = 0; q_rank[2] = 1; q_rank[3] = 0;
    apply();
    chk("R3 fcfs skip busy rank", sidx, 1);
    chk("R1 found", found, 1);
    ravail = 2'b00; apply();
    chk("R1 all ranks busy", found, 0);
  endtask

  task automatic t_timing();
    clear_q(); mode = 0; ravail = 2'b11;
    valid = 8'b0000_0100; apply();
    chk("R8 first", sidx, 2);
    valid = 8'b0001_0000;
    for (int i = 0; i < D; i++) begin
      rank_f[i] = q_rank[i][0];
    end
    #1 chk("R8 holds before edge", sidx, 2);
    @(negedge clk);
    chk("R8 after edge", sidx, 4);
  endtask

  task automatic t_single();
    clear_q(); mode = 1; ravail = 2'b01;
    valid = 8'b0010_0000; q_rank[5] = 1; q_bank[5] = 2; q_row[5] = 9;
    apply();
    chk("R2 single busy rank", found, 0);
    ravail = 2'b11; apply();
    chk("R2 single found", found, 1);
    chk("R2 single idx", sidx, 5);
  endtask

  task automatic t_hits();
    clear_q(); mode = 1; ravail = 2'b11; last_rank = 1'b1;
    valid = 8'b0000_0111;
    q_rank[0] = 0; q_bank[0] = 0; q_row[0] = 3; ropen[0] = 1; o_row[0] = 3;
    q_rank[1] = 1; q_bank[1] = 2; q_row[1] = 7; ropen[6] = 1; o_row[6] = 8;
    q_rank[2] = 1; q_bank[2] = 1; q_row[2] = 9; ropen[5] = 1; o_row[5] = 9;
    emask[6] = 1;
    apply();
    chk("R4 same-rank hit", sidx, 2);
    sw = 1; apply();
    chk("R4 switch oldest hit", sidx, 0);
    sw = 0; last_rank = 1'b0; apply();
    chk("R4 last rank 0", sidx, 0);
  endtask

  task automatic t_other_rank();
    clear_q(); mode = 1; ravail = 2'b11; last_rank = 1'b0;
    valid = 8'b0000_0111;
    q_rank[0] = 0; q_bank[0] = 0; q_row[0] = 1; emask[0] = 1;
    q_rank[1] = 0; q_bank[1] = 1; q_row[1] = 2;
    q_rank[2] = 1; q_bank[2] = 3; q_row[2] = 4; ropen[7] = 1; o_row[7] = 4;
    apply();
    chk("R5 other-rank hit wins", sidx, 2);
    chk("R7 bank id", sid, 7);
    chk("R7 group", sgrp, 1);
  endtask

  task automatic t_earliest();
    clear_q(); mode = 1; ravail = 2'b01;
    valid = 8'b0000_1111;
    q_rank[0] = 0; q_bank[0] = 0;
    q_rank[1] = 0; q_bank[1] = 1;
    q_rank[2] = 1; q_bank[2] = 2; emask[6] = 1;
    q_rank[3] = 0; q_bank[3] = 2; emask[2] = 1;
    apply();
    chk("R6 earliest on free rank", sidx, 3);
    chk("R7 bank id", sid, 2);
    chk("R7 group", sgrp, 0);
    emask[2] = 0; apply();
    chk("R6 nothing eligible", found, 0);
  endtask

  task automatic t_invalid();
    clear_q(); mode = 0; ravail = 2'b11;
    valid = 8'b0000_1010;
    q_rank[0] = 0; q_row[0] = 5; ropen[0] = 1; o_row[0] = 5;
    apply();
    chk("R9 invalid skipped", sidx, 1);
    valid = '0; apply();
    chk("R9 empty queue", found, 0);
  endtask

  task automatic t_random();
    bit ef; int ei, eid;
    for (int n = 0; n < 3000; n++) begin
      clear_q();
      mode = 1'($urandom); sw = 1'($urandom); last_rank = 1'($urandom);
      ravail = 2'($urandom); valid = 8'($urandom);
      if (n % 5 == 0) valid = 8'(1 << ($urandom % 8));
      ropen = 8'($urandom); emask = 8'($urandom);
      for (int b = 0; b < NB; b++) o_row[b] = $urandom % 4;
      for (int i = 0; i < D; i++) begin
        q_rank[i] = $urandom % NR; q_bank[i] = $urandom % NBK; q_row[i] = $urandom % 4;
      end
      apply();
      ref_pick(ef, ei);
      chk("R1 R2 R3 R4 R5 R6 random found", found, int'(ef));
      if (ef) begin
        eid = q_rank[ei] * NBK + q_bank[ei];
        chk("R4 R5 R6 random idx", sidx, ei);
        chk("R7 random id", sid, eid);
        chk("R7 random group", sgrp, q_bank[ei] % NG);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_q();
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_fcfs();
    t_timing();
    t_single();
    t_hits();
    t_other_rank();
    t_earliest();
    t_invalid();
    t_random();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule